// File: doc/BRIEF.md
# UART Register Bank and Interrupt Combiner

This block is the register file of a UART-style peripheral, seen by software through a word-indexed read/write bus. It stores the baud divisor pair, line control, control, level select and interrupt mask registers. It keeps a raw interrupt vector and derives the masked vector and one interrupt line from it. It also answers reads of a fixed identification window at the top of the map.

Transmission is modelled as instantaneous, so every write to the data offset raises the transmit interrupt. When loopback is enabled, the low byte of that write goes into an external receive FIFO. Data reads pop that FIFO and return the character together with the receive error bits. The FIFO itself lives outside the block and is connected through push, pop, fill-count, full and empty signals.

Top module: `uart_regbank`

## Requirements
- R1: After reset, level select reads 0x12, the divisor, line control, control and mask registers read 0, `irq_o` is low, and with an empty FIFO the flags offset (0x06) reads 0x90.
- R2: Writes keep only the implemented bits: integer divisor (0x09) 16 bits, fractional divisor (0x0A) 6 bits, line control (0x0B) 8 bits, control (0x0C) under mask 0xFFC7, level select (0x0D) 6 bits, interrupt mask (0x0E) 11 bits. A read returns the stored value.
- R3: `rdata_o` is loaded at the clock edge that samples `re_i` and holds its value in every cycle without a read strobe.
- R4: Every write to the data offset (0x00) sets raw bit 5 (transmit). When control bit 7 (loopback) is set, the write also pushes `wdata_i[7:0]` to the FIFO. When that bit is clear, nothing is pushed.
- R5: A loopback data write while the FIFO is full pushes nothing and sets bit 3 (overrun) of the receive status register (0x01). Any write to 0x01 clears that register. A read of 0x01 returns it.
- R6: A data read pops one character when the FIFO is not empty and returns the character in bits 7:0 and the receive status in bits 11:8. A data read of an empty FIFO pops nothing and returns 0 in bits 7:0.
- R7: Flags bit 7 is always 1. Bit 6 is set when the fill count equals the FIFO depth (16). Bit 4 is set when the fill count is 0.
- R8: A write to the clear offset (0x11) clears every raw bit whose write-data bit is 1. A read of 0x11 returns 0.
- R9: The masked status (0x10) equals raw status (0x0F) AND mask. `irq_o` is high exactly when the masked status is nonzero.
- R10: Raw bit 4 (receive level) sets when the fill count rises to the trigger level and clears once the count drops below it. With line control bit 4 (FIFO enable) clear, the trigger level is 1. With that bit set, level select bits 5:3 values 0..4 give 2, 4, 8, 12 or 14 characters, and any other value gives 16.
- R11: Raw bit 6 (receive timeout) sets when the FIFO turns non-empty and clears when it becomes empty.
- R12: Offsets 0x3F8..0x3FB return the bytes of 0x00241011 and offsets 0x3FC..0x3FF return the bytes of 0xB105F00D, least significant byte first.
- R13: Writes to read-only or unassigned offsets change no state, and reads of unassigned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offset_i | input | 10 | Word offset of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt line |
| fifo_push_o | output | 1 | Push one character into the receive FIFO |
| fifo_wdata_o | output | 8 | Character to push |
| fifo_pop_o | output | 1 | Pop the head character |
| fifo_rdata_i | input | 8 | Head character of the FIFO |
| fifo_count_i | input | 5 | FIFO fill count |
| fifo_full_i | input | 1 | FIFO full |
| fifo_empty_i | input | 1 | FIFO empty |

## Verification
The assertions take for granted that `we_i` and `re_i` never fire in the same cycle and that the FIFO's full and empty flags agree with its fill count. They also assume the head character is valid whenever the FIFO is not empty. The bench drives one access at a time and models the FIFO as a ring whose flags are derived from its own counter. It only injects received characters in cycles where the block issues no push, so the block's push and the injected character never meet.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int unsigned OFFS_W  = 10;
  localparam int unsigned NUM_IRQ = 11;

  localparam logic [OFFS_W-1:0] OFF_DATA  = 10'h000;
  localparam logic [OFFS_W-1:0] OFF_RSTAT = 10'h001;
  localparam logic [OFFS_W-1:0] OFF_FLAG  = 10'h006;
  localparam logic [OFFS_W-1:0] OFF_IDIV  = 10'h009;
  localparam logic [OFFS_W-1:0] OFF_FDIV  = 10'h00A;
  localparam logic [OFFS_W-1:0] OFF_LINE  = 10'h00B;
  localparam logic [OFFS_W-1:0] OFF_CTRL  = 10'h00C;
  localparam logic [OFFS_W-1:0] OFF_LVL   = 10'h00D;
  localparam logic [OFFS_W-1:0] OFF_MASK  = 10'h00E;
  localparam logic [OFFS_W-1:0] OFF_RAW   = 10'h00F;
  localparam logic [OFFS_W-1:0] OFF_MIS   = 10'h010;
  localparam logic [OFFS_W-1:0] OFF_CLR   = 10'h011;
  localparam logic [OFFS_W-1:0] OFF_IDWIN = 10'h3F8;

  localparam int unsigned IRQ_RXLVL = 4;
  localparam int unsigned IRQ_TX    = 5;
  localparam int unsigned IRQ_RXTO  = 6;
  localparam int unsigned RST_OVR   = 3;
  localparam int unsigned LINE_FEN  = 4;
  localparam int unsigned CTRL_LOOP = 7;

  localparam logic [15:0] CTRL_WMASK = 16'hFFC7;
  localparam logic [5:0]  LVL_RESET  = 6'h12;

  localparam logic [31:0] PERIPH_ID = 32'h0024_1011;
  localparam logic [31:0] CELL_ID   = 32'hB105_F00D;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [31:0] w;
    w = idx[2] ? CELL_ID : PERIPH_ID;
    return w[8*idx[1:0] +: 8];
  endfunction
endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       idiv_o,
  output logic [5:0]        fdiv_o,
  output logic [7:0]        line_o,
  output logic [15:0]       ctrl_o,
  output logic [5:0]        lvl_o,
  output logic [NUM_IRQ-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idiv_o <= '0;
      fdiv_o <= '0;
      line_o <= '0;
      ctrl_o <= '0;
      lvl_o  <= LVL_RESET;
      mask_o <= '0;
    end else if (we_i) begin
      unique case (offset_i)
        OFF_IDIV: idiv_o <= wdata_i;
        OFF_FDIV: fdiv_o <= wdata_i[5:0];
        OFF_LINE: line_o <= wdata_i[7:0];
        OFF_CTRL: ctrl_o <= wdata_i & CTRL_WMASK;
        OFF_LVL:  lvl_o  <= wdata_i[5:0];
        OFF_MASK: mask_o <= wdata_i[NUM_IRQ-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fen_i,
  input  logic [2:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             hit_o,
  output logic             nonempty_o,
  output logic             lvl_set_o,
  output logic             to_set_o
);
  logic [CNT_W-1:0] trig;
  logic             hit_q, nonempty_q;

  always_comb begin
    if (!fen_i) trig = CNT_W'(1);
    else begin
      unique case (sel_i)
        3'd0:    trig = CNT_W'(DEPTH / 8);
        3'd1:    trig = CNT_W'(DEPTH / 4);
        3'd2:    trig = CNT_W'(DEPTH / 2);
        3'd3:    trig = CNT_W'(DEPTH * 3 / 4);
        3'd4:    trig = CNT_W'(DEPTH * 7 / 8);
        default: trig = CNT_W'(DEPTH);
      endcase
    end
  end

  assign hit_o      = count_i >= trig;
  assign nonempty_o = count_i != '0;
  assign lvl_set_o  = hit_o && !hit_q;
  assign to_set_o   = nonempty_o && !nonempty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q      <= 1'b0;
      nonempty_q <= 1'b0;
    end else begin
      hit_q      <= hit_o;
      nonempty_q <= nonempty_o;
    end
  end
endmodule

// File: rtl/uart_irq_comb.sv
module uart_irq_comb #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] hold_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mis_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      raw_o[i] <= 1'b0;
      else if (set_i[i])                raw_o[i] <= 1'b1;
      else if (clr_i[i] || !hold_i[i])  raw_o[i] <= 1'b0;
    end
  end

  assign mis_o = raw_o & mask_i;
  assign irq_o = |mis_o;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fifo_push_o,
  output logic [7:0]        fifo_wdata_o,
  output logic              fifo_pop_o,
  input  logic [7:0]        fifo_rdata_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i
);
  logic [15:0]        idiv, ctrl;
  logic [5:0]         fdiv, lvl;
  logic [7:0]         line;
  logic [NUM_IRQ-1:0] mask, raw_st, mis, set_v, hold_v, clr_v;
  logic [3:0]         rsr_q;
  logic               loop_en, data_wr, hit, nonempty, lvl_set, to_set;
  logic [DATA_W-1:0]  rd_next;

  uart_cfg_regs u_cfg (
    .clk_i, .rst_ni, .we_i, .offset_i,
    .wdata_i (wdata_i[15:0]),
    .idiv_o  (idiv), .fdiv_o (fdiv), .line_o (line),
    .ctrl_o  (ctrl), .lvl_o  (lvl),  .mask_o (mask)
  );

  uart_rx_trigger #(.DEPTH(DEPTH)) u_trig (
    .clk_i, .rst_ni,
    .fen_i      (line[LINE_FEN]),
    .sel_i      (lvl[5:3]),
    .count_i    (fifo_count_i),
    .hit_o      (hit),
    .nonempty_o (nonempty),
    .lvl_set_o  (lvl_set),
    .to_set_o   (to_set)
  );

  assign loop_en      = ctrl[CTRL_LOOP];
  assign data_wr      = we_i && (offset_i == OFF_DATA);
  assign fifo_push_o  = data_wr && loop_en && !fifo_full_i;
  assign fifo_wdata_o = wdata_i[7:0];
  assign fifo_pop_o   = re_i && (offset_i == OFF_DATA) && !fifo_empty_i;

  always_comb begin
    set_v  = '0;
    hold_v = '1;
    set_v[IRQ_TX]     = data_wr;
    set_v[IRQ_RXLVL]  = lvl_set;
    set_v[IRQ_RXTO]   = to_set;
    hold_v[IRQ_RXLVL] = hit;
    hold_v[IRQ_RXTO]  = nonempty;
    clr_v = (we_i && offset_i == OFF_CLR) ? wdata_i[NUM_IRQ-1:0] : '0;
  end

  uart_irq_comb #(.N(NUM_IRQ)) u_irq (
    .clk_i, .rst_ni,
    .set_i  (set_v), .hold_i (hold_v), .clr_i (clr_v),
    .mask_i (mask),  .raw_o  (raw_st), .mis_o (mis),
    .irq_o
  );

  // receive status: overrun sets on a rejected loopback push, any write clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 rsr_q <= '0;
    else if (data_wr && loop_en && fifo_full_i)  rsr_q[RST_OVR] <= 1'b1;
    else if (we_i && offset_i == OFF_RSTAT)      rsr_q <= '0;
  end

  always_comb begin
    rd_next = '0;
    if (offset_i >= OFF_IDWIN) begin
      rd_next[7:0] = id_byte(offset_i[2:0]);
    end else begin
      unique case (offset_i)
        OFF_DATA: begin
          rd_next[7:0]  = fifo_empty_i ? 8'h00 : fifo_rdata_i;
          rd_next[11:8] = rsr_q;
        end
        OFF_RSTAT: rd_next[3:0] = rsr_q;
        OFF_FLAG: begin
          rd_next[7] = 1'b1;
          rd_next[6] = fifo_count_i == CNT_W'(DEPTH);
          rd_next[4] = fifo_count_i == '0;
        end
        OFF_IDIV: rd_next[15:0] = idiv;
        OFF_FDIV: rd_next[5:0]  = fdiv;
        OFF_LINE: rd_next[7:0]  = line;
        OFF_CTRL: rd_next[15:0] = ctrl;
        OFF_LVL:  rd_next[5:0]  = lvl;
        OFF_MASK: rd_next[NUM_IRQ-1:0] = mask;
        OFF_RAW:  rd_next[NUM_IRQ-1:0] = raw_st;
        OFF_MIS:  rd_next[NUM_IRQ-1:0] = mis;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OFFS_W-1:0] offset_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              fifo_push_o,
  input logic              fifo_pop_o,
  input logic              fifo_full_i,
  input logic              fifo_empty_i,
  input logic [NUM_IRQ-1:0] raw_st,
  input logic [3:0]        rsr_q,
  input logic              loop_en
);
  // R3
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  // R4
  tx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && offset_i == OFF_DATA) |=> raw_st[IRQ_TX]);
  // R5
  push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> !fifo_full_i);
  // R5
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && offset_i == OFF_DATA && loop_en && fifo_full_i) |=> rsr_q[RST_OVR]);
  // R6
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (!fifo_empty_i && re_i));
  // R8
  clear_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && offset_i == OFF_CLR && wdata_i[IRQ_TX]) |=> !raw_st[IRQ_TX]);
endmodule

bind uart_regbank uart_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .offset_i, .wdata_i, .we_i, .re_i, .rdata_o,
  .fifo_push_o, .fifo_pop_o, .fifo_full_i, .fifo_empty_i,
  .raw_st (raw_st), .rsr_q (rsr_q), .loop_en (loop_en)
);

// File: tb/tb_uart_regbank.sv
module tb_uart_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  offset = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  logic        push, pop;
  logic [7:0]  push_d, head;
  logic [4:0]  cnt;
  logic        full, empty;
  logic        ext_push = 1'b0;
  logic [7:0]  ext_data = '0;
  logic [7:0]  mem [16];
  logic [3:0]  wp, rp;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  uart_regbank dut (
    .clk_i (clk), .rst_ni (rst_n), .offset_i (offset), .wdata_i (wdata),
    .we_i (we), .re_i (re), .rdata_o (rdata), .irq_o (irq),
    .fifo_push_o (push), .fifo_wdata_o (push_d), .fifo_pop_o (pop),
    .fifo_rdata_i (head), .fifo_count_i (cnt),
    .fifo_full_i (full), .fifo_empty_i (empty)
  );

  // receive FIFO model
  assign full  = cnt == 5'd16;
  assign empty = cnt == 5'd0;
  assign head  = mem[rp];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; wp <= '0; rp <= '0;
    end else begin
      logic do_push;
      logic [7:0] d;
      do_push = push || (ext_push && !full);
      d = push ? push_d : ext_data;
      if (do_push) begin mem[wp] <= d; wp <= wp + 4'd1; end
      if (pop) rp <= rp + 4'd1;
      cnt <= cnt + 5'(do_push) - 5'(pop);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] o, input logic [31:0] d);
    offset = o; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] o, output logic [31:0] d);
    offset = o; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic inject(input logic [7:0] d);
    ext_push = 1'b1; ext_data = d;
    @(negedge clk);
    ext_push = 1'b0;
  endtask

  function automatic logic [31:0] wmask(input logic [9:0] o);
    case (o)
      10'h009: return 32'hFFFF;
      10'h00A: return 32'h3F;
      10'h00B: return 32'hFF;
      10'h00C: return 32'hFFC7;
      10'h00D: return 32'h3F;
      10'h00E: return 32'h7FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int trig_of(input logic fen, input int sel);
    if (!fen) return 1;
    case (sel)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 12;
      4: return 14;
      default: return 16;
    endcase
  endfunction

  function automatic logic [7:0] id_exp(input int i);
    logic [31:0] w;
    w = (i < 4) ? 32'h0024_1011 : 32'hB105_F00D;
    return w[8*(i%4) +: 8];
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v0;
    logic [9:0]  o;
    logic [31:0] tx_m, msk_m;
    int nchar;
    void'($urandom(32'h1234_5678));
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(10'h00D, v); check("R1 level select", v, 32'h12);
    rd(10'h00E, v); check("R1 mask", v, 32'h0);
    rd(10'h00C, v); check("R1 control", v, 32'h0);
    rd(10'h009, v); check("R1 int divisor", v, 32'h0);
    rd(10'h006, v); check("R7 flags empty", v, 32'h90);

    // R2 / R13 random config writes
    for (int i = 0; i < 40; i++) begin
      int k;
      k = $urandom_range(0, 7);
      v0 = $urandom;
      if (k < 6) begin
        o = 10'(9 + k);
        wr(o, v0);
        rd(o, v);
        check("R2 write mask", v, v0 & wmask(o));
      end else begin
        o = 10'(10'h012 + $urandom_range(0, 10'h3F8 - 10'h013));
        wr(o, v0);
        rd(o, v);
        check("R13 unassigned read", v, 32'h0);
      end
    end
    wr(10'h00B, 0); wr(10'h00C, 0); wr(10'h00E, 0); wr(10'h00D, 32'h12);
    wr(10'h011, 32'h7FF);

    // R3 read data held without strobe
    wr(10'h009, 32'h1357);
    rd(10'h009, v0);
    wr(10'h009, 32'h2468);
    idle(1);
    check("R3 rdata hold", rdata, v0);
    rd(10'h009, v); check("R3 read latency", v, 32'h2468);

    // R4 / R8 / R9 transmit interrupt, no loopback
    wr(10'h000, 32'h55);
    idle(1);
    rd(10'h00F, v); check("R4 tx raw", v, 32'h20);
    rd(10'h006, v); check("R4 no push without loopback", v, 32'h90);
    check("R9 irq masked off", {31'b0, irq}, 32'h0);
    wr(10'h00E, 32'h20);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    rd(10'h010, v); check("R9 masked status", v, 32'h20);
    wr(10'h011, 32'h20);
    check("R8 irq cleared", {31'b0, irq}, 32'h0);
    rd(10'h00F, v); check("R8 raw cleared", v, 32'h0);
    rd(10'h011, v); check("R8 clear reads 0", v, 32'h0);
    wr(10'h00E, 32'h0);

    // R4 / R6 / R10 / R11 loopback single character
    wr(10'h00C, 32'h80);
    wr(10'h000, 32'h1A5);
    idle(1);
    rd(10'h006, v); check("R4 loopback push flags", v, 32'h80);
    rd(10'h00F, v); check("R11 raw after push", v, 32'h70);
    rd(10'h000, v); check("R6 data read", v, 32'hA5);
    idle(1);
    rd(10'h00F, v); check("R11 raw after empty", v, 32'h20);
    rd(10'h000, v); check("R6 empty read", v, 32'h0);
    rd(10'h006, v); check("R6 no pop when empty", v, 32'h90);

    // R5 / R7 fill, overrun, drain
    for (int i = 0; i < 16; i++) wr(10'h000, 32'(i * 7 + 3));
    rd(10'h006, v); check("R7 flags full", v, 32'hC0);
    wr(10'h000, 32'hEE);
    rd(10'h001, v); check("R5 overrun", v, 32'h8);
    rd(10'h006, v); check("R5 no push when full", v, 32'hC0);
    rd(10'h000, v); check("R6 data with status", v, 32'h803);
    wr(10'h001, 32'h0);
    rd(10'h001, v); check("R5 status cleared", v, 32'h0);
    for (int i = 1; i < 16; i++) begin
      rd(10'h000, v); check("R6 drain order", v, 32'(i * 7 + 3));
    end
    rd(10'h006, v); check("R7 flags after drain", v, 32'h90);
    wr(10'h00C, 0);
    wr(10'h011, 32'h7FF);

    // R10 trigger levels
    for (int fe = 0; fe < 2; fe++) begin
      for (int sel = 0; sel < 6; sel++) begin
        int t;
        if (fe == 0 && sel != 2) continue;
        wr(10'h00B, fe ? 32'h10 : 32'h0);
        wr(10'h00D, 32'(sel << 3));
        t = trig_of(fe[0], sel);
        nchar = 0;
        while (nchar < t) begin
          inject(8'(nchar));
          nchar++;
          idle(1);
          rd(10'h00F, v);
          check("R10 level bit", {31'b0, v[4]}, {31'b0, nchar >= t});
        end
        rd(10'h000, v);
        nchar--;
        idle(1);
        rd(10'h00F, v);
        check("R10 level drop", {31'b0, v[4]}, 32'h0);
        while (nchar > 0) begin rd(10'h000, v); nchar--; end
        wr(10'h011, 32'h7FF);
      end
    end
    wr(10'h00B, 0);
    wr(10'h00D, 32'h12);

    // R12 identification window
    for (int i = 0; i < 8; i++) begin
      rd(10'(10'h3F8 + i), v);
      check("R12 id byte", v, {24'b0, id_exp(i)});
    end

    // R13 read-only offsets ignore writes
    wr(10'h00F, 32'hFFFF);
    wr(10'h006, 32'hFFFF);
    rd(10'h00F, v); check("R13 raw write ignored", v, 32'h0);
    rd(10'h006, v); check("R13 flags write ignored", v, 32'h90);

    // R8 / R9 random interrupt traffic
    tx_m = 0; msk_m = 0;
    for (int i = 0; i < 40; i++) begin
      int k;
      k = $urandom_range(0, 2);
      v0 = $urandom;
      if (k == 0) begin wr(10'h000, v0); tx_m = 32'h20; end
      else if (k == 1) begin wr(10'h011, v0); if (v0[5]) tx_m = 0; end
      else begin wr(10'h00E, v0); msk_m = v0 & 32'h7FF; end
      check("R9 irq level", {31'b0, irq}, {31'b0, |(tx_m & msk_m)});
      rd(10'h010, v); check("R9 masked status", v, tx_m & msk_m);
      rd(10'h00F, v); check("R8 raw status", v, tx_m);
    end

    finish_run();
  end
endmodule